// File: doc/BRIEF.md
# Lookahead In-Order Ready Pointer

This block follows a circular queue and keeps a pointer to its oldest entry that is not yet ready. Each entry has three status bits (allocated, valid, uncached) and an extra vector flag. An entry counts as ready when it is allocated, it has at least one of the other three marks, and it is not the slot the enqueue pointer names. Each cycle the block looks at a short window of consecutive entries that starts at its pointer. It then moves the pointer past the leading run of ready entries in that window, so the pointer can skip several entries in one cycle.

Each pointer is an index with a wrap flag beside it. When a pipeline redirect occurs, the pointer is reloaded from one of two sources. If the commit pointer is strictly ahead of the dequeue pointer, the commit pointer is used. Otherwise the next-cycle dequeue pointer is used, because uncached entries can leave the queue before they commit. The block also publishes a registered per-entry ready vector built from the allocated, valid and uncached bits only. The queue storage and the logic that sets the status bits are not part of this block.

Top module: `rptr_tracker`

## Requirements
- R1: After reset, the pointer index, its wrap flag and every bit of the ready vector are zero.
- R2: Each cycle, the scan covers exactly WINDOW (default 4) consecutive positions, starting at the pointer. Positions wrap modulo DEPTH (default 16), and the wrap flag toggles when a position passes DEPTH-1.
- R3: A scanned entry is ready when its allocated bit is set and at least one of its uncached, valid or vector-flag bits is set. An entry that is allocated but has none of those three bits set is not ready and holds the pointer in place.
- R4: Without a redirect, the next pointer is the current pointer plus the number of ready entries before the first not-ready one in the window. The advance is at most WINDOW per cycle.
- R5: The position equal to the enqueue pointer (index and flag) is never ready, so the pointer stops on it. A position with the same index but the opposite flag is not blocked.
- R6: On a redirect, the pointer loads the commit pointer when the commit pointer is strictly after the dequeue pointer. "Strictly after" means: (flags differ) XOR (commit index > dequeue index).
- R7: On a redirect where the commit pointer is not strictly after the dequeue pointer (equal pointers included), the pointer loads the next-dequeue pointer.
- R8: When a redirect and a possible advance fall in the same cycle, the redirect reload wins.
- R9: Ready-vector bit i equals allocated[i] AND (uncached[i] OR valid[i]) from the previous cycle. The vector flag has no effect on it.
- R10: The pointer's wrap flag toggles exactly when an advance carries the index past DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| alloc_vec | input | DEPTH | Per-entry allocated bits |
| valid_vec | input | DEPTH | Per-entry valid bits |
| uncached_vec | input | DEPTH | Per-entry uncached bits |
| vflag_vec | input | DEPTH | Per-entry vector flags (count as ready in the scan only) |
| enq_flag | input | 1 | Enqueue pointer wrap flag |
| enq_idx | input | log2(DEPTH) | Enqueue pointer index |
| deq_flag | input | 1 | Dequeue pointer wrap flag |
| deq_idx | input | log2(DEPTH) | Dequeue pointer index |
| deq_next_flag | input | 1 | Next-cycle dequeue pointer wrap flag |
| deq_next_idx | input | log2(DEPTH) | Next-cycle dequeue pointer index |
| cmt_flag | input | 1 | Commit pointer wrap flag |
| cmt_idx | input | log2(DEPTH) | Commit pointer index |
| redirect | input | 1 | Pipeline redirect strobe |
| rdy_flag | output | 1 | Ready pointer wrap flag |
| rdy_idx | output | log2(DEPTH) | Ready pointer index |
| ready_vec | output | DEPTH | Registered per-entry ready vector |

## Verification
The directed patterns cover several cases. Empty status vectors check that the pointer stays put. A long fully-ready run checks the four-entry cap, which shows up as steps of four. A run that ends on the enqueue slot shows the stop there. A window mixing vector-only, uncached-only, valid-only and bare-allocated entries shows which marks count in the scan and which reach the ready vector. A run across the queue end shows the flag toggle. Redirects are tried with the commit pointer ahead on the same flag, ahead across a flag change, and equal to the dequeue pointer. One redirect falls in a fully ready window to show the reload has priority. A long random phase then mixes all inputs against the cycle model.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

  // Which source the pointer register takes this cycle.
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_SCAN   = 2'd1,
    SRC_COMMIT = 2'd2,
    SRC_DEQNXT = 2'd3
  } ptr_src_e;

endpackage

// File: rtl/rptr_window_scan.sv
module rptr_window_scan #(
  parameter int DEPTH  = 16,
  parameter int WINDOW = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1,
  localparam int CW = $clog2(WINDOW + 1)
) (
  input  logic [PW-1:0]    cur_ptr,
  input  logic [PW-1:0]    enq_ptr,
  input  logic [DEPTH-1:0] alloc_vec,
  input  logic [DEPTH-1:0] valid_vec,
  input  logic [DEPTH-1:0] uncached_vec,
  input  logic [DEPTH-1:0] vflag_vec,
  output logic [CW-1:0]    advance
);

  logic [WINDOW-1:0] slot_ready;

  // One lookup per window position; the PW-wide add carries into the flag.
  for (genvar k = 0; k < WINDOW; k++) begin : g_slot
    logic [PW-1:0] pos;
    logic [IW-1:0] idx;
    assign pos = cur_ptr + PW'(k);
    assign idx = pos[IW-1:0];
    assign slot_ready[k] = alloc_vec[idx]
                         & (uncached_vec[idx] | valid_vec[idx] | vflag_vec[idx])
                         & (pos != enq_ptr);
  end

  // First not-ready slot, with an implicit sentinel at WINDOW.
  always_comb begin
    advance = CW'(WINDOW);
    for (int k = WINDOW - 1; k >= 0; k--) begin
      if (!slot_ready[k]) advance = CW'(k);
    end
  end

endmodule

// File: rtl/rptr_redirect_sel.sv
module rptr_redirect_sel #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic [PW-1:0] cmt_ptr,
  input  logic [PW-1:0] deq_ptr,
  input  logic [PW-1:0] deq_next_ptr,
  output logic          cmt_ahead,
  output logic [PW-1:0] reload_ptr
);

  logic flag_diff;
  logic idx_gt;

  assign flag_diff = cmt_ptr[PW-1] ^ deq_ptr[PW-1];
  assign idx_gt    = cmt_ptr[IW-1:0] > deq_ptr[IW-1:0];
  assign cmt_ahead = flag_diff ^ idx_gt;

  always_comb begin
    reload_ptr = deq_next_ptr;
    if (cmt_ahead) reload_ptr = cmt_ptr;
  end

endmodule

// File: rtl/rptr_ready_vec.sv
module rptr_ready_vec #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_vec,
  input  logic [DEPTH-1:0] valid_vec,
  input  logic [DEPTH-1:0] uncached_vec,
  output logic [DEPTH-1:0] ready_q
);

  logic [DEPTH-1:0] ready_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    assign ready_d[i] = alloc_vec[i] & (uncached_vec[i] | valid_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= '0;
    else        ready_q <= ready_d;
  end

endmodule

// File: rtl/rptr_tracker.sv
module rptr_tracker #(
  parameter int DEPTH  = 16,
  parameter int WINDOW = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1,
  localparam int CW = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_vec,
  input  logic [DEPTH-1:0] valid_vec,
  input  logic [DEPTH-1:0] uncached_vec,
  input  logic [DEPTH-1:0] vflag_vec,
  input  logic             enq_flag,
  input  logic [IW-1:0]    enq_idx,
  input  logic             deq_flag,
  input  logic [IW-1:0]    deq_idx,
  input  logic             deq_next_flag,
  input  logic [IW-1:0]    deq_next_idx,
  input  logic             cmt_flag,
  input  logic [IW-1:0]    cmt_idx,
  input  logic             redirect,
  output logic             rdy_flag,
  output logic [IW-1:0]    rdy_idx,
  output logic [DEPTH-1:0] ready_vec
);
  import rptr_pkg::*;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic          ptr_en;
  logic [CW-1:0] advance;
  logic [PW-1:0] reload_ptr;
  logic          cmt_ahead;
  ptr_src_e      src;

  rptr_window_scan #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_scan (
    .cur_ptr      (ptr_q),
    .enq_ptr      ({enq_flag, enq_idx}),
    .alloc_vec    (alloc_vec),
    .valid_vec    (valid_vec),
    .uncached_vec (uncached_vec),
    .vflag_vec    (vflag_vec),
    .advance      (advance)
  );

  rptr_redirect_sel #(.DEPTH(DEPTH)) u_redir (
    .cmt_ptr      ({cmt_flag, cmt_idx}),
    .deq_ptr      ({deq_flag, deq_idx}),
    .deq_next_ptr ({deq_next_flag, deq_next_idx}),
    .cmt_ahead    (cmt_ahead),
    .reload_ptr   (reload_ptr)
  );

  rptr_ready_vec #(.DEPTH(DEPTH)) u_rvec (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_vec    (alloc_vec),
    .valid_vec    (valid_vec),
    .uncached_vec (uncached_vec),
    .ready_q      (ready_vec)
  );

  // Source select: redirect first, then scan advance, else hold.
  always_comb begin
    if (redirect)             src = cmt_ahead ? SRC_COMMIT : SRC_DEQNXT;
    else if (advance != '0)   src = SRC_SCAN;
    else                      src = SRC_HOLD;
  end

  always_comb begin
    ptr_en = 1'b1;
    ptr_d  = ptr_q;
    unique case (src)
      SRC_COMMIT, SRC_DEQNXT: ptr_d = reload_ptr;
      SRC_SCAN:               ptr_d = ptr_q + PW'(advance);
      default:                ptr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign rdy_flag = ptr_q[PW-1];
  assign rdy_idx  = ptr_q[IW-1:0];

endmodule

// File: rtl/rptr_tracker_chk.sv
module rptr_tracker_chk #(
  parameter int DEPTH  = 16,
  parameter int WINDOW = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DEPTH-1:0] alloc_vec,
  input logic [DEPTH-1:0] valid_vec,
  input logic [DEPTH-1:0] uncached_vec,
  input logic [DEPTH-1:0] vflag_vec,
  input logic             enq_flag,
  input logic [IW-1:0]    enq_idx,
  input logic             deq_flag,
  input logic [IW-1:0]    deq_idx,
  input logic             deq_next_flag,
  input logic [IW-1:0]    deq_next_idx,
  input logic             cmt_flag,
  input logic [IW-1:0]    cmt_idx,
  input logic             redirect,
  input logic             rdy_flag,
  input logic [IW-1:0]    rdy_idx,
  input logic [DEPTH-1:0] ready_vec
);

  logic [PW-1:0] cur;
  logic          head_ready;
  logic          commit_ahead;

  assign cur        = {rdy_flag, rdy_idx};
  assign head_ready = alloc_vec[rdy_idx]
                    & (uncached_vec[rdy_idx] | valid_vec[rdy_idx] | vflag_vec[rdy_idx])
                    & (cur != {enq_flag, enq_idx});
  assign commit_ahead = (cmt_flag ^ deq_flag) ^ (cmt_idx > deq_idx);

  // R4
  adv_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> PW'(cur - $past(cur)) <= PW'(WINDOW));

  // R3
  head_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && !head_ready) |=> $stable(cur));

  // R6
  reload_cmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && commit_ahead) |=> cur == $past({cmt_flag, cmt_idx}));

  // R7
  reload_deqn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !commit_ahead) |=> cur == $past({deq_next_flag, deq_next_idx}));

  // R9
  rvec_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ready_vec == $past(alloc_vec & (uncached_vec | valid_vec)));

endmodule

bind rptr_tracker rptr_tracker_chk #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_chk (.*);

// File: tb/tb_rptr_tracker.sv
module tb_rptr_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 16;
  localparam int W  = 4;
  localparam int IW = $clog2(D);

  logic          clk;
  logic          rst_n;
  logic [D-1:0]  alloc_vec, valid_vec, uncached_vec, vflag_vec;
  logic [IW:0]   enq_p, deq_p, dn_p, cmt_p;
  logic          redirect;
  logic          rdy_flag;
  logic [IW-1:0] rdy_idx;
  logic [D-1:0]  ready_vec;

  int checks;
  int failures;
  bit done;
  int mptr;
  logic [D-1:0] mrv;

  rptr_tracker #(.DEPTH(D), .WINDOW(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_vec(alloc_vec), .valid_vec(valid_vec),
    .uncached_vec(uncached_vec), .vflag_vec(vflag_vec),
    .enq_flag(enq_p[IW]), .enq_idx(enq_p[IW-1:0]),
    .deq_flag(deq_p[IW]), .deq_idx(deq_p[IW-1:0]),
    .deq_next_flag(dn_p[IW]), .deq_next_idx(dn_p[IW-1:0]),
    .cmt_flag(cmt_p[IW]), .cmt_idx(cmt_p[IW-1:0]),
    .redirect(redirect),
    .rdy_flag(rdy_flag), .rdy_idx(rdy_idx), .ready_vec(ready_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit m_after(int a, int b);
    return ((a / D) != (b / D)) != ((a % D) > (b % D));
  endfunction

  task automatic compare(string tag);
    int got;
    got = int'({rdy_flag, rdy_idx});
    checks++;
    if (got != mptr) begin
      failures++;
      $display("FAIL %s pointer actual=%0d expected=%0d", tag, got, mptr);
    end
    checks++;
    if (ready_vec !== mrv) begin
      failures++;
      $display("FAIL %s ready_vec actual=%h expected=%h", tag, ready_vec, mrv);
    end
  endtask

  // Model one clock from the inputs now applied, then compare.
  task automatic step(string tag);
    int nptr;
    logic [D-1:0] nrv;
    if (redirect) begin
      nptr = m_after(int'(cmt_p), int'(deq_p)) ? int'(cmt_p) : int'(dn_p);
    end else begin
      int adv;
      adv = W;
      for (int k = W - 1; k >= 0; k--) begin
        int p;
        bit r;
        p = (mptr + k) % (2 * D);
        r = alloc_vec[p % D] && (valid_vec[p % D] || uncached_vec[p % D] || vflag_vec[p % D])
            && (p != int'(enq_p));
        if (!r) adv = k;
      end
      nptr = (mptr + adv) % (2 * D);
    end
    for (int i = 0; i < D; i++) nrv[i] = alloc_vec[i] && (valid_vec[i] || uncached_vec[i]);
    @(posedge clk);
    @(negedge clk);
    mptr = nptr;
    mrv  = nrv;
    compare(tag);
  endtask

  task automatic clear_all();
    alloc_vec = '0; valid_vec = '0; uncached_vec = '0; vflag_vec = '0;
    redirect = 1'b0;
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    mptr = 0; mrv = '0;
    rst_n = 1'b0;
    clear_all();
    enq_p = '0; deq_p = '0; dn_p = '0; cmt_p = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    // R3: nothing ready, pointer holds
    step("R3"); step("R3");

    // R4 / R5: ten ready entries, enqueue at 10
    for (int i = 0; i < 10; i++) begin alloc_vec[i] = 1; valid_vec[i] = 1; end
    enq_p = 10;
    step("R4"); step("R4"); step("R5"); step("R5");

    // R3 / R9: mixed marks at 10..13, enqueue moved to flag1 idx4
    enq_p = 5'd20;
    alloc_vec[13:10] = 4'hF;
    vflag_vec[10] = 1; uncached_vec[11] = 1; valid_vec[12] = 1;
    step("R3"); step("R9"); step("R3");

    // R10 / R2: wrap across the queue end, enqueue at flag1 idx8
    alloc_vec = '1; valid_vec = '1; enq_p = 5'd24;
    step("R10"); step("R10"); step("R10"); step("R2");

    // R6: commit ahead on same flag
    redirect = 1; cmt_p = 5'd18; deq_p = 5'd16; dn_p = 5'd17;
    step("R6");
    // R7: equal pointers take next-dequeue
    cmt_p = 5'd16;
    step("R7");
    // R6: commit ahead across a flag change
    cmt_p = 5'd3; deq_p = 5'd30; dn_p = 5'd31;
    step("R6");
    // R8: reload wins over a fully ready window
    enq_p = 5'd0; cmt_p = 5'd5; deq_p = 5'd9; dn_p = 5'd12;
    step("R8");
    redirect = 0;
    step("R4");

    // R2: random mix
    for (int n = 0; n < 600; n++) begin
      alloc_vec    = D'($urandom) | D'($urandom);
      valid_vec    = D'($urandom) & D'($urandom);
      uncached_vec = D'($urandom) & D'($urandom) & D'($urandom);
      vflag_vec    = D'($urandom) & D'($urandom) & D'($urandom);
      enq_p = (IW+1)'($urandom);
      deq_p = (IW+1)'($urandom);
      dn_p  = (IW+1)'($urandom);
      cmt_p = (IW+1)'($urandom);
      redirect = (($urandom % 8) == 0);
      step("R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule